// File: doc/BRIEF.md
# Capture and Toggle-Compare Timer Channel

This block is one channel of a general-purpose timer. A free-running up-counter advances once every PSC+1 module clocks. It counts from zero up to a reload value and then wraps back to zero. The wrap is the only thing that ever returns the counter to zero, so the reload value alone sets the counter period. The channel runs in one of two modes, chosen by a control bit.

In capture mode, an external input passes through a two-flop synchronizer and an edge detector. The selected edge polarity is then thinned by an edge decimator that passes every 1st, 2nd, 4th or 8th edge. Each edge that passes copies the counter into a capture register and raises a capture flag. If a capture arrives while that flag is still pending, an overcapture flag is set as well. An update flag marks every counter wrap, so software can account for overflow when it measures the interval between captures.

In toggle-compare mode, the output pin inverts each time the counter steps onto the compare value. Software may rewrite the compare register at any time. Adding a fixed interval after each match gives a waveform whose period is independent of the reload value. Software reaches the channel through a flat write/read register port. The registers are: control (address 0), clock prescaler (1), reload (2), compare (3), capture (4, read only), flags (5) and counter (6, read only).

Top module: `cap_cmp_timer`

## Requirements
- R1: While the enable bit (control bit 0) is 1, the counter (address 6) advances by one after every PSC+1 clocks (PSC at address 1). When it is at or above the reload value (address 2), it goes to 0 instead of advancing. While enable is 0 it holds its value.
- R2: The update flag (flags bit 2) is set on every counter wrap to zero.
- R3: With control bit 1 set to 1 (compare mode), the output pin inverts exactly when the counter steps onto the value in the compare register (address 3). A match never restarts the counter. A compare value above the reload value never toggles the pin.
- R4: A write to the compare register takes effect for the next counter step, with no shadow copy, so software can move the next match within a period.
- R5: With control bit 1 set to 0 (capture mode), the channel captures on a rising input edge when control bit 2 is 0, and on a falling edge when it is 1. The capture register (address 4) receives the counter value held two clocks after the input change. The capture flag (flags bit 0) is then set.
- R6: Control bits 4:3 hold a code k. With code k, only every 2^k-th selected edge (1, 2, 4 or 8) produces a capture and a flag.
- R7: Any write to the control register clears the edge decimator's count, so the next capture needs a fresh 2^k selected edges.
- R8: A capture that occurs while the capture flag is already set also sets the overcapture flag (flags bit 1).
- R9: Writing 1 to a flags bit clears that flag. Writing 0 to a bit leaves it unchanged.
- R10: Input edges produce no capture and no flag in compare mode or while the channel is disabled.
- R11: After reset, every register reads 0 except reload, which reads all ones, and the output pin is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 3 | Register address for both read and write |
| wrData | input | CNT_W | Write data |
| rdData | output | CNT_W | Read data, combinational from addr |
| capIn | input | 1 | External capture input, asynchronous |
| cmpOut | output | 1 | Toggle-compare output pin |

## Verification
The hardest situation to reach is a capture that lands on a predictable counter value after the edge decimator has dropped some edges and the counter has wrapped. The bench drives each input change on a known clock. It tracks the number of clocks since enable and computes, by arithmetic, the counter value two clocks after every change. It sweeps both polarities across all four decimation codes, with a prescaled counter that wraps in the middle of the sequence. Clearing the decimator is checked by rewriting the control register in the middle of a group of edges. The compare-register rewrite is placed on a specific clock while the counter is running.

// File: rtl/cap_cmp_timer_pkg.sv
package cap_cmp_timer_pkg;

  localparam int REG_ADDR_W = 3;

  localparam logic [REG_ADDR_W-1:0] ADDR_CTRL   = 3'd0;
  localparam logic [REG_ADDR_W-1:0] ADDR_PSC    = 3'd1;
  localparam logic [REG_ADDR_W-1:0] ADDR_RELOAD = 3'd2;
  localparam logic [REG_ADDR_W-1:0] ADDR_CMP    = 3'd3;
  localparam logic [REG_ADDR_W-1:0] ADDR_CAPT   = 3'd4;
  localparam logic [REG_ADDR_W-1:0] ADDR_FLAGS  = 3'd5;
  localparam logic [REG_ADDR_W-1:0] ADDR_CNT    = 3'd6;

  localparam int FLAG_CAP = 0;
  localparam int FLAG_OVR = 1;
  localparam int FLAG_UPD = 2;

  // Packed so that en is bit 0 and capDiv is bits 4:3 of the control word.
  typedef struct packed {
    logic [1:0] capDiv;
    logic       fallEdge;
    logic       cmpMode;
    logic       en;
  } tmrCfg_t;

  localparam int CFG_W = $bits(tmrCfg_t);

  typedef struct packed {
    logic edgeClr;
  } tmrStrobe_t;

  typedef struct packed {
    logic capture;
    logic wrap;
  } tmrEvent_t;

endpackage

// File: rtl/cap_cmp_timer_datapath.sv
module cap_cmp_timer_datapath
  import cap_cmp_timer_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int DIV_W       = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmrCfg_t          cfg,
  input  tmrStrobe_t       strobe,
  input  logic [CNT_W-1:0] pscReg,
  input  logic [CNT_W-1:0] reloadReg,
  input  logic [CNT_W-1:0] cmpReg,
  input  logic             capIn,
  output logic [CNT_W-1:0] cntVal,
  output logic [CNT_W-1:0] capVal,
  output logic             cmpOut,
  output tmrEvent_t        evt
);

  localparam int HIST_W = SYNC_STAGES + 1;

  // ---------------- clock prescaler and counter ----------------
  logic [CNT_W-1:0] pscCnt;
  logic [CNT_W-1:0] cntNext;
  logic             tick;
  logic             atTop;

  assign tick    = cfg.en && (pscCnt >= pscReg);
  assign atTop   = cntVal >= reloadReg;
  assign cntNext = atTop ? '0 : cntVal + 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pscCnt <= '0;
    end else if (cfg.en) begin
      pscCnt <= tick ? '0 : pscCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntVal <= '0;
    end else if (tick) begin
      cntVal <= cntNext;
    end
  end

  // ---------------- toggle compare ----------------
  logic cmpHit;

  assign cmpHit = tick && cfg.cmpMode && (cntNext == cmpReg);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmpOut <= 1'b0;
    end else if (cmpHit) begin
      cmpOut <= ~cmpOut;
    end
  end

  // ---------------- input synchronizer and edge detect ----------------
  logic [HIST_W-1:0] syncQ;
  logic              syncNow;
  logic              syncOld;
  logic              edgeSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '0;
    end else begin
      syncQ <= {syncQ[HIST_W-2:0], capIn};
    end
  end

  assign syncNow = syncQ[SYNC_STAGES-1];
  assign syncOld = syncQ[SYNC_STAGES];
  assign edgeSel = cfg.en && !cfg.cmpMode &&
                   (cfg.fallEdge ? (syncOld && !syncNow) : (syncNow && !syncOld));

  // ---------------- edge decimator ----------------
  logic [DIV_W-1:0] edgeCnt;
  logic [DIV_W-1:0] edgeLast;
  logic             capHit;

  always_comb begin
    edgeLast = '0;
    for (int b = 0; b < DIV_W; b++) begin
      if (b < int'(cfg.capDiv)) edgeLast[b] = 1'b1;
    end
  end

  assign capHit = edgeSel && !strobe.edgeClr && (edgeCnt == edgeLast);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      edgeCnt <= '0;
    end else if (strobe.edgeClr || !cfg.en) begin
      edgeCnt <= '0;
    end else if (edgeSel) begin
      edgeCnt <= (edgeCnt == edgeLast) ? '0 : edgeCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capVal <= '0;
    end else if (capHit) begin
      capVal <= cntVal;
    end
  end

  assign evt.capture = capHit;
  assign evt.wrap    = tick && atTop;

endmodule

// File: rtl/cap_cmp_timer_ctrl.sv
module cap_cmp_timer_ctrl
  import cap_cmp_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [REG_ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]      wrData,
  output logic [CNT_W-1:0]      rdData,
  input  tmrEvent_t             evt,
  input  logic [CNT_W-1:0]      cntVal,
  input  logic [CNT_W-1:0]      capVal,
  output tmrCfg_t               cfg,
  output tmrStrobe_t            strobe,
  output logic [CNT_W-1:0]      pscReg,
  output logic [CNT_W-1:0]      reloadReg,
  output logic [CNT_W-1:0]      cmpReg,
  output logic                  capFlag,
  output logic                  ovrFlag,
  output logic                  updFlag
);

  logic wrCtrl, wrFlags;
  logic clrCap, clrOvr, clrUpd;

  assign wrCtrl  = wrEn && (addr == ADDR_CTRL);
  assign wrFlags = wrEn && (addr == ADDR_FLAGS);
  assign clrCap  = wrFlags && wrData[FLAG_CAP];
  assign clrOvr  = wrFlags && wrData[FLAG_OVR];
  assign clrUpd  = wrFlags && wrData[FLAG_UPD];

  assign strobe.edgeClr = wrCtrl;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg       <= '0;
      pscReg    <= '0;
      reloadReg <= '1;
      cmpReg    <= '0;
    end else if (wrEn) begin
      case (addr)
        ADDR_CTRL:   cfg       <= tmrCfg_t'(wrData[CFG_W-1:0]);
        ADDR_PSC:    pscReg    <= wrData;
        ADDR_RELOAD: reloadReg <= wrData;
        ADDR_CMP:    cmpReg    <= wrData;
        default: ;
      endcase
    end
  end

  // Hardware set takes priority over a software clear in the same cycle.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capFlag <= 1'b0;
      ovrFlag <= 1'b0;
      updFlag <= 1'b0;
    end else begin
      if (evt.capture)                capFlag <= 1'b1;
      else if (clrCap)                capFlag <= 1'b0;
      if (evt.capture && capFlag)     ovrFlag <= 1'b1;
      else if (clrOvr)                ovrFlag <= 1'b0;
      if (evt.wrap)                   updFlag <= 1'b1;
      else if (clrUpd)                updFlag <= 1'b0;
    end
  end

  always_comb begin
    rdData = '0;
    case (addr)
      ADDR_CTRL:   rdData[CFG_W-1:0] = cfg;
      ADDR_PSC:    rdData = pscReg;
      ADDR_RELOAD: rdData = reloadReg;
      ADDR_CMP:    rdData = cmpReg;
      ADDR_CAPT:   rdData = capVal;
      ADDR_FLAGS: begin
        rdData[FLAG_CAP] = capFlag;
        rdData[FLAG_OVR] = ovrFlag;
        rdData[FLAG_UPD] = updFlag;
      end
      ADDR_CNT:    rdData = cntVal;
      default:     rdData = '0;
    endcase
  end

endmodule

// File: rtl/cap_cmp_timer.sv
module cap_cmp_timer
  import cap_cmp_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [REG_ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]      wrData,
  output logic [CNT_W-1:0]      rdData,
  input  logic                  capIn,
  output logic                  cmpOut
);

  tmrCfg_t          cfg;
  tmrStrobe_t       strobe;
  tmrEvent_t        evt;
  logic [CNT_W-1:0] pscReg, reloadReg, cmpReg;
  logic [CNT_W-1:0] cntVal, capVal;
  logic             capFlag, ovrFlag, updFlag;

  cap_cmp_timer_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .addr      (addr),
    .wrData    (wrData),
    .rdData    (rdData),
    .evt       (evt),
    .cntVal    (cntVal),
    .capVal    (capVal),
    .cfg       (cfg),
    .strobe    (strobe),
    .pscReg    (pscReg),
    .reloadReg (reloadReg),
    .cmpReg    (cmpReg),
    .capFlag   (capFlag),
    .ovrFlag   (ovrFlag),
    .updFlag   (updFlag)
  );

  cap_cmp_timer_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .cfg       (cfg),
    .strobe    (strobe),
    .pscReg    (pscReg),
    .reloadReg (reloadReg),
    .cmpReg    (cmpReg),
    .capIn     (capIn),
    .cntVal    (cntVal),
    .capVal    (capVal),
    .cmpOut    (cmpOut),
    .evt       (evt)
  );

endmodule

// File: rtl/cap_cmp_timer_chk.sv
module cap_cmp_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic [CNT_W-1:0] cntVal,
  input logic [CNT_W-1:0] capVal,
  input logic [CNT_W-1:0] cmpReg,
  input logic             cmpOut,
  input logic             capFlag,
  input logic             ovrFlag,
  input logic             updFlag
);

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(cntVal) |-> (cntVal == CNT_W'($past(cntVal) + 1'b1)) || (cntVal == '0)); // R1

  AST_UPD_ON_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    ($past(cntVal) != '0 && cntVal == '0) |-> updFlag); // R2

  AST_PIN_AT_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(cmpOut) |-> (cntVal == $past(cmpReg))); // R3

  AST_CAPT_WITH_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(capVal) |-> capFlag); // R5

  AST_OVR_WITH_CAP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovrFlag) |-> capFlag); // R8

endmodule

bind cap_cmp_timer cap_cmp_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .cntVal  (cntVal),
  .capVal  (capVal),
  .cmpReg  (cmpReg),
  .cmpOut  (cmpOut),
  .capFlag (capFlag),
  .ovrFlag (ovrFlag),
  .updFlag (updFlag)
);

// File: tb/cap_cmp_timer_bench.sv
`timescale 1ns/1ps
module cap_cmp_timer_bench;
  import cap_cmp_timer_pkg::*;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         wrEn = 1'b0;
  logic         capIn = 1'b0;
  logic [2:0]   addr = '0;
  logic [W-1:0] wrData = '0;
  logic [W-1:0] rdData;
  logic         cmpOut;

  int nChk = 0;
  int nFail = 0;
  int cyc = 0;
  int tEn = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cap_cmp_timer #(.CNT_W(W)) u_cap_cmp_timer (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .capIn(capIn), .cmpOut(cmpOut)
  );

  task automatic check(string tag, logic [W-1:0] got, logic [W-1:0] exp);
    nChk++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic int expCnt(int j, int p, int r);
    return (j / (p + 1)) % (r + 1);
  endfunction

  function automatic logic [W-1:0] cfgWord(bit en, bit cmp, bit fall, int k);
    return W'({k[1:0], fall, cmp, en});
  endfunction

  task automatic wr(logic [2:0] a, logic [W-1:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [W-1:0] v);
    addr = a;
    #1;
    v = rdData;
  endtask

  task automatic doReset();
    rstN = 1'b0; wrEn = 1'b0; capIn = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic enable(logic [W-1:0] c);
    wr(ADDR_CTRL, c);
    tEn = cyc;
  endtask

  // Drive one selected edge, check flag and capture, then return to idle.
  task automatic capEdge(bit act, int p, int r, bit expFlag, string tag);
    logic [W-1:0] v;
    int c0;
    capIn = act;
    c0 = cyc;
    repeat (3) @(negedge clk);
    rd(ADDR_FLAGS, v);
    check({tag, " flag"}, W'(v[FLAG_CAP]), W'(expFlag));
    check({tag, " ovr"}, W'(v[FLAG_OVR]), W'(0));
    if (expFlag) begin
      rd(ADDR_CAPT, v);
      check({tag, " capt"}, v, W'(expCnt(c0 + 2 - tEn, p, r)));
      wr(ADDR_FLAGS, W'(1));
    end
    capIn = ~act;
    repeat (3) @(negedge clk);
  endtask

  task automatic runCnt(int p, int r);
    logic [W-1:0] v;
    int j;
    int frozen;
    doReset();
    wr(ADDR_PSC, W'(p));
    wr(ADDR_RELOAD, W'(r));
    enable(cfgWord(1, 0, 0, 0));
    for (int s = 1; s <= 30; s++) begin
      @(negedge clk);
      j = cyc - tEn;
      rd(ADDR_CNT, v);
      check($sformatf("R1 cnt p=%0d r=%0d s=%0d", p, r, s), v, W'(expCnt(j, p, r)));
      rd(ADDR_FLAGS, v);
      check($sformatf("R2 upd p=%0d r=%0d s=%0d", p, r, s), W'(v[FLAG_UPD]),
            W'((j / (p + 1)) > r));
    end
    wr(ADDR_CTRL, cfgWord(0, 0, 0, 0));
    frozen = expCnt(cyc - tEn, p, r);
    repeat (5) @(negedge clk);
    rd(ADDR_CNT, v);
    check("R1 hold while disabled", v, W'(frozen));
    wr(ADDR_FLAGS, W'(0));
    rd(ADDR_FLAGS, v);
    check("R9 zero write keeps flag", v, W'(4));
    wr(ADDR_FLAGS, W'(4));
    rd(ADDR_FLAGS, v);
    check("R9 one write clears flag", v, W'(0));
  endtask

  task automatic runCmp(int p, int r, int cmp0, int wrAt, int newCmp, int steps);
    logic [W-1:0] v;
    int curCmp;
    int j;
    logic pin;
    curCmp = cmp0;
    pin = 1'b0;
    doReset();
    wr(ADDR_PSC, W'(p));
    wr(ADDR_RELOAD, W'(r));
    wr(ADDR_CMP, W'(cmp0));
    enable(cfgWord(1, 1, 0, 0));
    for (int s = 1; s <= steps; s++) begin
      bit wrote;
      wrote = (s == wrAt);
      if (wrote) begin
        wrEn = 1'b1; addr = ADDR_CMP; wrData = W'(newCmp);
      end
      @(negedge clk);
      wrEn = 1'b0;
      j = cyc - tEn;
      if ((j % (p + 1)) == 0 && expCnt(j, p, r) == curCmp) pin = ~pin;
      if (wrote) curCmp = newCmp;
      // R3 pin toggles on entry to compare value; R4 after the rewrite
      check($sformatf("R3/R4 pin p=%0d cmp=%0d s=%0d", p, curCmp, s), W'(cmpOut), W'(pin));
      rd(ADDR_CNT, v);
      check($sformatf("R3 no restart s=%0d", s), v, W'(expCnt(j, p, r)));
    end
  endtask

  logic [W-1:0] rv;
  int c1;

  initial begin
    doReset();
    // R11 reset state
    rd(ADDR_CTRL, rv);   check("R11 ctrl", rv, W'(0));
    rd(ADDR_PSC, rv);    check("R11 psc", rv, W'(0));
    rd(ADDR_RELOAD, rv); check("R11 reload", rv, '1);
    rd(ADDR_CMP, rv);    check("R11 cmp", rv, W'(0));
    rd(ADDR_CAPT, rv);   check("R11 capt", rv, W'(0));
    rd(ADDR_FLAGS, rv);  check("R11 flags", rv, W'(0));
    rd(ADDR_CNT, rv);    check("R11 cnt", rv, W'(0));
    check("R11 pin", W'(cmpOut), W'(0));

    // R1 / R2 / R9 counter sweep
    runCnt(0, 3);
    runCnt(0, 7);
    runCnt(2, 3);
    runCnt(1, 5);

    // R3 / R4 compare
    runCmp(0, 9, 4, 0, 0, 40);
    runCmp(1, 9, 4, 0, 0, 50);
    runCmp(0, 9, 4, 12, 7, 45);
    runCmp(1, 9, 12, 0, 0, 50);

    // R5 / R6 capture sweep over polarity and decimation
    for (int fall = 0; fall < 2; fall++) begin
      for (int k = 0; k < 4; k++) begin
        int n;
        n = 1 << k;
        doReset();
        wr(ADDR_PSC, W'(1));
        wr(ADDR_RELOAD, W'(13));
        capIn = fall[0];
        repeat (3) @(negedge clk);
        enable(cfgWord(1, 0, fall[0], k));
        for (int i = 0; i < 2 * n; i++) begin
          capEdge(~fall[0], 1, 13, (i % n) == n - 1,
                  $sformatf("R5/R6 fall=%0d k=%0d edge=%0d", fall, k, i));
        end
      end
    end

    // R7 control write clears the decimator count
    doReset();
    wr(ADDR_RELOAD, W'(1000));
    enable(cfgWord(1, 0, 0, 2));
    capEdge(1'b1, 0, 1000, 1'b0, "R7 pre e0");
    capEdge(1'b1, 0, 1000, 1'b0, "R7 pre e1");
    wr(ADDR_CTRL, cfgWord(1, 0, 0, 2));
    capEdge(1'b1, 0, 1000, 1'b0, "R7 post e0");
    capEdge(1'b1, 0, 1000, 1'b0, "R7 post e1");
    capEdge(1'b1, 0, 1000, 1'b0, "R7 post e2");
    capEdge(1'b1, 0, 1000, 1'b1, "R7 post e3");

    // R8 overcapture, R9 selective clear
    doReset();
    wr(ADDR_RELOAD, W'(1000));
    enable(cfgWord(1, 0, 0, 0));
    capIn = 1'b1; repeat (3) @(negedge clk);
    capIn = 1'b0; repeat (3) @(negedge clk);
    capIn = 1'b1; c1 = cyc; repeat (3) @(negedge clk);
    rd(ADDR_FLAGS, rv);  check("R8 cap and ovr set", rv[2:0] & 3'b011, 3'b011);
    rd(ADDR_CAPT, rv);   check("R8 second capture value", rv, W'(expCnt(c1 + 2 - tEn, 0, 1000)));
    wr(ADDR_FLAGS, W'(2));
    rd(ADDR_FLAGS, rv);  check("R9 clear ovr only", rv[2:0] & 3'b011, 3'b001);
    wr(ADDR_FLAGS, W'(1));
    rd(ADDR_FLAGS, rv);  check("R9 clear cap", rv[2:0] & 3'b011, 3'b000);
    capIn = 1'b0; repeat (3) @(negedge clk);

    // R10 edges ignored in compare mode and while disabled
    doReset();
    wr(ADDR_RELOAD, W'(1000));
    wr(ADDR_CMP, W'(900));
    enable(cfgWord(1, 1, 0, 0));
    for (int i = 0; i < 3; i++) begin
      capIn = 1'b1; repeat (3) @(negedge clk);
      capIn = 1'b0; repeat (3) @(negedge clk);
    end
    rd(ADDR_FLAGS, rv);  check("R10 compare mode flag", W'(rv[FLAG_CAP]), W'(0));
    rd(ADDR_CAPT, rv);   check("R10 compare mode capt", rv, W'(0));
    wr(ADDR_CTRL, cfgWord(0, 0, 0, 0));
    for (int i = 0; i < 3; i++) begin
      capIn = 1'b1; repeat (3) @(negedge clk);
      capIn = 1'b0; repeat (3) @(negedge clk);
    end
    rd(ADDR_FLAGS, rv);  check("R10 disabled flag", W'(rv[FLAG_CAP]), W'(0));
    rd(ADDR_CAPT, rv);   check("R10 disabled capt", rv, W'(0));

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChk++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nChk, nFail);
      $finish;
    end
  end

endmodule